// File: doc/BRIEF.md
# I2C Sensor Bus Power and Connect Sequencer

This block owns the supply rail and the pin routing of an external I2C sensor bus that a bridge uses on demand. A requester asks for the bus with an enable request and gives it back with a disable request. The block answers each accepted enable with a one-cycle response that reports ok or busy. It brings the bus up in a fixed order: the rail first, then the input routing, then the output routing, then a one-cycle init pulse to the I2C master. It tears the bus down in the reverse order. The bus counts as enabled exactly when the active-low rail enable is low, and no other enabled flag exists.

A disable can carry a debounce flag. A debounced disable does not act at once. It arms a one-second timer, so a burst of back-to-back transactions keeps the bus powered. A later enable cancels the timer, and a later debounced disable restarts it. When a conflicting debug probe is attached, an enable is refused with busy, and the bus is torn down if it was up. All delays are counted in clock cycles derived from the `CLK_HZ` parameter. The rail settle time comes from `SETTLE_US` and the disable hold time from `HOLD_MS`.

The controller has eight states. OFF and ON are idle states. RAMP, LINK_IN, LINK_OUT and INIT form the power-up path, and UNLINK_OUT and UNLINK_IN form the power-down path.

Transitions:
- OFF→RAMP on an accepted enable with no probe attached.
- RAMP→LINK_IN when the settle count ends.
- LINK_IN→LINK_OUT→INIT→ON, one cycle each.
- ON→UNLINK_OUT on any of these:
  - an immediate disable;
  - an enable refused because of the probe;
  - expiry of the hold timer.
- UNLINK_OUT→UNLINK_IN→OFF, one cycle each.

OFF and ON otherwise stay where they are.

Top module: `i2c_bus_power_seq`

## Requirements
- R1: After reset the outputs are as follows: `rail_en_n`=1, both mux selects 0, `init_pulse`=0, `seq_busy`=0 and `rsp_valid`=0.
- R2: The power-up sequence runs as follows:
  - `rail_en_n` goes low for SETTLE_CYC = ceil(CLK_HZ·SETTLE_US/10⁶) cycles with both selects 0;
  - then `in_mux_sel`=1 alone for one cycle;
  - then `out_mux_sel`=1 for one cycle;
  - then `init_pulse`=1 for exactly one cycle with both selects 1;
  - then the bus is on.
- R3: An accepted enable gives `rsp_valid`=1 for the one cycle after the accepting edge, with `rsp_busy`=0 when ok. An enable on a bus that is already on answers ok and changes no other output.
- R4: An enable while `probe_attached`=1 answers `rsp_busy`=1 and never powers up. If the bus was on, the refusal starts power-down at once.
- R5: An immediate disable (`dis_debounce`=0) on an enabled bus runs the power-down sequence:
  - `out_mux_sel` drops first;
  - `in_mux_sel` drops one cycle later;
  - `rail_en_n` rises one cycle after that.
- R6: A disable request while the bus is off has no effect on any output.
- R7: A debounced disable starts power-down HOLD_CYC = CLK_HZ/1000·HOLD_MS clock edges after the edge that accepts it.
- R8: A new debounced disable restarts the hold count from its own accepting edge rather than adding a second timer.
- R9: An accepted enable cancels a pending debounced disable, so the bus stays on past the original expiry.
- R10: Requests that arrive while `seq_busy`=1 are captured and acted on in the first idle cycle. A captured disable keeps its debounce flag.
- R11: If an enable and a disable are present in the same idle cycle, the enable is served and the disable is discarded.
- R12: `seq_busy` is 1 exactly in the six power-up and power-down states and 0 in OFF and ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_req | input | 1 | Enable request, one cycle |
| dis_req | input | 1 | Disable request, one cycle |
| dis_debounce | input | 1 | With `dis_req`: 1 delays power-down by the hold time |
| probe_attached | input | 1 | A conflicting debug probe owns the pins |
| rsp_valid | output | 1 | One-cycle response to an accepted enable |
| rsp_busy | output | 1 | With `rsp_valid`: 1 = refused (busy), 0 = ok |
| rail_en_n | output | 1 | Bus supply enable, active low |
| in_mux_sel | output | 1 | Routes bus pads into the I2C master inputs |
| out_mux_sel | output | 1 | Routes I2C master outputs onto the bus pads |
| init_pulse | output | 1 | One-cycle initialisation strobe for the I2C master |
| seq_busy | output | 1 | A power-up or power-down sequence is in progress |

## Verification
The hardest situation to reach from the ports is a request that lands inside a sequence and has to be replayed later. That includes a disable that arrives during the rail settle time and an enable that arrives in the middle of power-down. The stimulus reaches it by issuing the second request a fixed number of cycles after the first, timed so that it falls inside RAMP or UNLINK_OUT. Restarting and cancelling the hold timer is the other hard case. It is reached by issuing a second debounced disable or an enable halfway through the hold window and then watching past the original expiry point. The bench runs with a shortened hold time so that these windows stay short.

// File: rtl/i2cpwr_pkg.sv
package i2cpwr_pkg;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_RAMP,
        PS_LINK_IN,
        PS_LINK_OUT,
        PS_INIT,
        PS_ON,
        PS_UNLINK_OUT,
        PS_UNLINK_IN
    } pwr_state_t;

    typedef struct packed {
        logic en;
        logic dis;
        logic deb;
    } pwr_req_t;

endpackage

// File: rtl/i2cpwr_req_hold.sv
module i2cpwr_req_hold
    import i2cpwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy,
    input  logic     en_req,
    input  logic     dis_req,
    input  logic     dis_debounce,
    output pwr_req_t merged
);

    pwr_req_t held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (busy) begin
            if (en_req) begin
                held.en <= 1'b1;
            end
            if (dis_req) begin
                held.dis <= 1'b1;
                held.deb <= dis_debounce;
            end
        end else begin
            held <= '0;
        end
    end

    always_comb begin
        merged.en  = en_req | held.en;
        merged.dis = dis_req | held.dis;
        merged.deb = dis_req ? dis_debounce : held.deb;
    end

endmodule

// File: rtl/i2cpwr_cycle_timer.sv
module i2cpwr_cycle_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic fire
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] left;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (cancel) begin
            armed <= 1'b0;
        end else if (start) begin
            armed <= 1'b1;
            left  <= CW'(CYCLES - 1);
        end else if (armed) begin
            if (left == '0) begin
                armed <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    assign fire = armed && (left == '0);

endmodule

// File: rtl/i2cpwr_fsm.sv
module i2cpwr_fsm
    import i2cpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_req_t   req,
    input  logic       probe_attached,
    input  logic       ramp_done,
    input  logic       hold_done,
    output logic       ramp_start,
    output logic       hold_arm,
    output logic       hold_cancel,
    output logic       busy,
    output logic       rsp_valid,
    output logic       rsp_busy,
    output logic       rail_en_n,
    output logic       in_mux_sel,
    output logic       out_mux_sel,
    output logic       init_pulse
);

    pwr_state_t state, nxt;
    logic       acc_en;
    logic       acc_refuse;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= PS_OFF;
            rsp_valid <= 1'b0;
            rsp_busy  <= 1'b0;
        end else begin
            state     <= nxt;
            rsp_valid <= acc_en;
            rsp_busy  <= acc_en & acc_refuse;
        end
    end

    // next state and timer control
    always_comb begin
        nxt         = state;
        ramp_start  = 1'b0;
        hold_arm    = 1'b0;
        hold_cancel = 1'b0;
        acc_en      = 1'b0;
        acc_refuse  = 1'b0;
        unique case (state)
            PS_OFF: begin
                if (req.en) begin
                    acc_en      = 1'b1;
                    hold_cancel = 1'b1;
                    if (probe_attached) begin
                        acc_refuse = 1'b1;
                    end else begin
                        nxt        = PS_RAMP;
                        ramp_start = 1'b1;
                    end
                end
            end
            PS_RAMP:     if (ramp_done) nxt = PS_LINK_IN;
            PS_LINK_IN:  nxt = PS_LINK_OUT;
            PS_LINK_OUT: nxt = PS_INIT;
            PS_INIT:     nxt = PS_ON;
            PS_ON: begin
                if (req.en) begin
                    acc_en      = 1'b1;
                    hold_cancel = 1'b1;
                    if (probe_attached) begin
                        acc_refuse = 1'b1;
                        nxt        = PS_UNLINK_OUT;
                    end
                end else if (req.dis) begin
                    if (req.deb) begin
                        hold_arm = 1'b1;
                    end else begin
                        hold_cancel = 1'b1;
                        nxt         = PS_UNLINK_OUT;
                    end
                end else if (hold_done) begin
                    nxt = PS_UNLINK_OUT;
                end
            end
            PS_UNLINK_OUT: nxt = PS_UNLINK_IN;
            PS_UNLINK_IN:  nxt = PS_OFF;
            default:       nxt = PS_OFF;
        endcase
    end

    // outputs
    always_comb begin
        rail_en_n   = 1'b0;
        in_mux_sel  = 1'b0;
        out_mux_sel = 1'b0;
        init_pulse  = 1'b0;
        busy        = 1'b1;
        unique case (state)
            PS_OFF: begin
                rail_en_n = 1'b1;
                busy      = 1'b0;
            end
            PS_RAMP: ;
            PS_LINK_IN:  in_mux_sel = 1'b1;
            PS_LINK_OUT: begin
                in_mux_sel  = 1'b1;
                out_mux_sel = 1'b1;
            end
            PS_INIT: begin
                in_mux_sel  = 1'b1;
                out_mux_sel = 1'b1;
                init_pulse  = 1'b1;
            end
            PS_ON: begin
                in_mux_sel  = 1'b1;
                out_mux_sel = 1'b1;
                busy        = 1'b0;
            end
            PS_UNLINK_OUT: in_mux_sel = 1'b1;
            PS_UNLINK_IN: ;
            default: begin
                rail_en_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/i2c_bus_power_seq.sv
module i2c_bus_power_seq
    import i2cpwr_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_US = 25,
    parameter int unsigned HOLD_MS   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic dis_debounce,
    input  logic probe_attached,
    output logic rsp_valid,
    output logic rsp_busy,
    output logic rail_en_n,
    output logic in_mux_sel,
    output logic out_mux_sel,
    output logic init_pulse,
    output logic seq_busy
);

    localparam int unsigned KHZ        = CLK_HZ / 1000;
    localparam int unsigned SETTLE_RAW = (KHZ * SETTLE_US + 999) / 1000;
    localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int unsigned HOLD_RAW   = KHZ * HOLD_MS;
    localparam int unsigned HOLD_CYC   = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

    pwr_req_t req;
    logic     ramp_start, ramp_done;
    logic     hold_arm, hold_cancel, hold_done;

    i2cpwr_req_hold u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (seq_busy),
        .en_req       (en_req),
        .dis_req      (dis_req),
        .dis_debounce (dis_debounce),
        .merged       (req)
    );

    i2cpwr_cycle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ramp_start),
        .cancel (1'b0),
        .fire   (ramp_done)
    );

    i2cpwr_cycle_timer #(.CYCLES(HOLD_CYC)) u_linger (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_arm),
        .cancel (hold_cancel),
        .fire   (hold_done)
    );

    i2cpwr_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (req),
        .probe_attached (probe_attached),
        .ramp_done      (ramp_done),
        .hold_done      (hold_done),
        .ramp_start     (ramp_start),
        .hold_arm       (hold_arm),
        .hold_cancel    (hold_cancel),
        .busy           (seq_busy),
        .rsp_valid      (rsp_valid),
        .rsp_busy       (rsp_busy),
        .rail_en_n      (rail_en_n),
        .in_mux_sel     (in_mux_sel),
        .out_mux_sel    (out_mux_sel),
        .init_pulse     (init_pulse)
    );

endmodule

// File: rtl/i2c_bus_power_seq_chk.sv
module i2c_bus_power_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rsp_valid,
    input logic rsp_busy,
    input logic rail_en_n,
    input logic in_mux_sel,
    input logic out_mux_sel,
    input logic init_pulse,
    input logic seq_busy
);

    assert_in_after_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_mux_sel) |-> (!rail_en_n && !out_mux_sel));

    assert_out_needs_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_mux_sel |-> (in_mux_sel && !rail_en_n));

    assert_init_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    assert_init_linked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |-> (in_mux_sel && out_mux_sel));

    assert_in_drop_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_mux_sel) |-> !out_mux_sel);

    assert_rail_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en_n) |-> (!in_mux_sel && !out_mux_sel));

    assert_busy_tags_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_busy |-> rsp_valid);

    assert_refused_unlinked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_busy |-> !out_mux_sel);

    assert_partial_is_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mux_sel != out_mux_sel) |-> seq_busy);

endmodule

bind i2c_bus_power_seq i2c_bus_power_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (rsp_valid),
    .rsp_busy    (rsp_busy),
    .rail_en_n   (rail_en_n),
    .in_mux_sel  (in_mux_sel),
    .out_mux_sel (out_mux_sel),
    .init_pulse  (init_pulse),
    .seq_busy    (seq_busy)
);

// File: tb/i2c_bus_power_seq_bench.sv
`timescale 1ns/1ps
module i2c_bus_power_seq_bench;

    // 1 MHz nominal rate for the delay parameters: 25 settle cycles, 1000 hold cycles
    localparam int S = 25;
    localparam int H = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0, dis_debounce = 1'b0, probe_attached = 1'b0;
    logic rsp_valid, rsp_busy, rail_en_n, in_mux_sel, out_mux_sel, init_pulse, seq_busy;

    always #2.5 clk = ~clk;

    i2c_bus_power_seq #(.CLK_HZ(1_000_000), .SETTLE_US(25), .HOLD_MS(1)) u_i2c_bus_power_seq (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .dis_debounce(dis_debounce), .probe_attached(probe_attached),
        .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .rail_en_n(rail_en_n),
        .in_mux_sel(in_mux_sel), .out_mux_sel(out_mux_sel),
        .init_pulse(init_pulse), .seq_busy(seq_busy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference: mode 0 off, 1 rising, 2 on, 3 falling
    int m_mode = 0, m_k = 0, t_left = 0;
    bit t_on = 0, p_en = 0, p_dis = 0, p_deb = 0, m_rv = 0, m_rb = 0;

    always @(posedge clk) begin
        bit ren, rdis, rdeb, fire, cancel, arm;
        if (!rst_n) begin
            m_mode = 0; m_k = 0; t_on = 0; t_left = 0;
            p_en = 0; p_dis = 0; p_deb = 0; m_rv = 0; m_rb = 0;
        end else begin
            fire = t_on && (t_left == 0);
            cancel = 0; arm = 0; m_rv = 0; m_rb = 0;
            if (m_mode == 0 || m_mode == 2) begin
                ren = en_req | p_en;
                rdis = dis_req | p_dis;
                rdeb = dis_req ? dis_debounce : p_deb;
                p_en = 0; p_dis = 0; p_deb = 0;
                if (ren) begin
                    m_rv = 1; cancel = 1;
                    if (probe_attached) begin
                        m_rb = 1;
                        if (m_mode == 2) begin m_mode = 3; m_k = 0; end
                    end else if (m_mode == 0) begin
                        m_mode = 1; m_k = 0;
                    end
                end else if (m_mode == 2 && rdis) begin
                    if (rdeb) arm = 1;
                    else begin cancel = 1; m_mode = 3; m_k = 0; end
                end else if (m_mode == 2 && fire) begin
                    m_mode = 3; m_k = 0;
                end
            end else begin
                if (en_req) p_en = 1;
                if (dis_req) begin p_dis = 1; p_deb = dis_debounce; end
                m_k++;
                if (m_mode == 1 && m_k == S + 3) m_mode = 2;
                if (m_mode == 3 && m_k == 2) m_mode = 0;
            end
            if (cancel) t_on = 0;
            else if (arm) begin t_on = 1; t_left = H - 1; end
            else if (t_on) begin
                if (t_left == 0) t_on = 0; else t_left--;
            end
        end
    end

    task automatic cmp1(string name, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        logic e_rail, e_in, e_out, e_init, e_busy;
        if (rst_n && !done) begin
            e_rail = 0; e_in = 0; e_out = 0; e_init = 0; e_busy = 1;
            case (m_mode)
                0: begin e_rail = 1; e_busy = 0; end
                1: begin
                    e_in = (m_k >= S);
                    e_out = (m_k >= S + 1);
                    e_init = (m_k == S + 2);
                end
                2: begin e_in = 1; e_out = 1; e_busy = 0; end
                default: e_in = (m_k == 0);
            endcase
            cmp1("rail_en_n", rail_en_n, e_rail);
            cmp1("in_mux_sel", in_mux_sel, e_in);
            cmp1("out_mux_sel", out_mux_sel, e_out);
            cmp1("init_pulse", init_pulse, e_init);
            cmp1("seq_busy", seq_busy, e_busy);
            cmp1("rsp_valid", rsp_valid, m_rv);
            cmp1("rsp_busy", rsp_busy, m_rb);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(bit e, bit d, bit db);
        en_req = e; dis_req = d; dis_debounce = db;
        @(negedge clk);
        en_req = 0; dis_req = 0; dis_debounce = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; wait_n(4);
        // R2 full power-up order
        tag = "R2"; req(1, 0, 0); wait_n(S + 8);
        // R3 enable while on: ok response, nothing moves
        tag = "R3"; req(1, 0, 0); wait_n(5);
        // R5 immediate disable, reverse order
        tag = "R5"; req(0, 1, 0); wait_n(6);
        // R6 disable while off has no effect
        tag = "R6"; req(0, 1, 0); wait_n(3); req(0, 1, 1); wait_n(H + 10);
        // R7 debounced disable
        tag = "R7"; req(1, 0, 0); wait_n(S + 6); req(0, 1, 1); wait_n(H + 10);
        // R8 restart of the hold window
        tag = "R8"; req(1, 0, 0); wait_n(S + 6); req(0, 1, 1); wait_n(H / 2);
        req(0, 1, 1); wait_n(H / 2 + 50); wait_n(H / 2 + 10);
        // R9 enable cancels pending delayed disable
        tag = "R9"; req(1, 0, 0); wait_n(S + 6); req(0, 1, 1); wait_n(H / 2);
        req(1, 0, 0); wait_n(H + 20); req(0, 1, 0); wait_n(5);
        // R4 probe attached: refuse while off, tear down while on
        tag = "R4"; probe_attached = 1; req(1, 0, 0); wait_n(5);
        probe_attached = 0; req(1, 0, 0); wait_n(S + 6);
        probe_attached = 1; req(1, 0, 0); wait_n(6); probe_attached = 0;
        // R10 requests captured during sequences
        tag = "R10"; req(1, 0, 0); wait_n(3); req(0, 1, 0); wait_n(S + 12);
        req(1, 0, 0); wait_n(S + 6); req(0, 1, 0); req(1, 0, 0); wait_n(S + 8);
        req(0, 1, 0); req(0, 1, 1); wait_n(H + 10);
        // R11 simultaneous enable and disable
        tag = "R11"; req(1, 1, 0); wait_n(S + 6); req(1, 1, 0); wait_n(5);
        req(0, 1, 0); wait_n(5);
        // R12 busy coverage across one more full cycle
        tag = "R12"; req(1, 0, 0); wait_n(S + 6); req(0, 1, 0); wait_n(5);
        finish_run();
    end

endmodule